// File: doc/BRIEF.md
# Dual-Clock FIFO Controller with Boundary Flags

This block controls a FIFO whose writer and reader each run on their own clock. It holds no data itself. Instead it drives the write enable and write address of an external dual-port RAM from the push side, and the read address of the same RAM from the pop side. The RAM shows the word at the read address before the pop that consumes it. Each side keeps a binary pointer one bit wider than the RAM address. The pointer is copied into the opposite clock domain as a Gray code value through a chain of synchronizer flops.

Each side runs a small level state machine. The pop side has the states `RD_EMPTY`, `RD_LOW`, `RD_MID` and `RD_HIGH`. The push side has the states `WR_LOW`, `WR_HALF`, `WR_NEAR` and `WR_FULL`. Every clock, the next state is taken from the occupancy that the local pointer will have after this cycle's request, measured against the synchronized pointer of the other side. Because the state is picked from that next occupancy, any state can follow any other state in one cycle:

- A pop from `RD_LOW` with no new write seen moves the pop side to `RD_EMPTY`.
- A newly seen write moves it from `RD_EMPTY` to `RD_LOW` or higher.
- A push with no pop seen moves the push side from `WR_NEAR` to `WR_FULL`.
- A pop seen on the push side moves it from `WR_FULL` back down.

The state is named after the occupancy band it holds: empty, at or below the almost-empty threshold, below half, and so on. The flags are decoded from the state register. A request on a side that is at its limit is dropped and raises that side's error output for one cycle.

Top module: `dcfifo_ctrl`

## Requirements
- R1: After its own active-low reset, the pop side reports empty=1, almost-empty=1, half=0 and error=0. The push side reports full=0, almost-full=0, half=0 and error=0. Both addresses start at 0.
- R2: A push (push_n sampled 0) that is taken raises wr_en in the same cycle. After the edge, wr_addr advances by one modulo DEPTH=2^ADDR_W, so the n-th accepted push writes address (n-1) mod DEPTH.
- R3: A pop (pop_n sampled 0) with the FIFO not empty advances rd_addr by one modulo DEPTH. Words come out of the RAM in the order they were pushed.
- R4: Once the pointers have settled, rd_empty=1 exactly when the occupancy is 0, and rd_aempty=1 when the occupancy is at most AE_LVL (default 1). Empty can only rise in the cycle after a pop.
- R5: Once settled, wr_full=1 exactly when the occupancy equals DEPTH, and wr_afull=1 when the occupancy is at least DEPTH-AF_LVL (default 1). Full can only rise in the cycle after a push.
- R6: Once settled, rd_half and wr_half are both 1 when the occupancy is at least DEPTH/2.
- R7: With one word stored, a pop taken on a pop edge that closely follows a push edge drives rd_empty to 1 right after that pop edge. The push is not yet visible on the pop side. The new word then shows up later and is read out intact.
- R8: With DEPTH-1 words stored, a push taken on a push edge that closely precedes a pop edge drives wr_full to 1 right after that push edge. The pop then releases it.
- R9: During a run of back-to-back pops down to empty, a push arriving within four pop cycles before empty leaves the flags correct and the data in order. The same holds for back-to-back pushes up to full with a pop arriving within four push cycles before full.
- R10: A push while full is dropped: wr_addr does not move and the stored data is untouched. wr_err is 1 for the one cycle after that edge.
- R11: A pop while empty is dropped: rd_addr does not move. rd_err is 1 for the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Push-side clock |
| wrst_n | input | 1 | Push-side asynchronous reset, active low |
| push_n | input | 1 | Push request, active low |
| wr_en | output | 1 | RAM write enable |
| wr_addr | output | ADDR_W | RAM write address |
| wr_full | output | 1 | Push side: FIFO full |
| wr_afull | output | 1 | Push side: at or above DEPTH-AF_LVL words |
| wr_half | output | 1 | Push side: at least half full |
| wr_err | output | 1 | One-cycle pulse for a push refused while full |
| rclk | input | 1 | Pop-side clock |
| rrst_n | input | 1 | Pop-side asynchronous reset, active low |
| pop_n | input | 1 | Pop request, active low |
| rd_en | output | 1 | Pop accepted this cycle |
| rd_addr | output | ADDR_W | RAM read address (the word shown before the pop) |
| rd_empty | output | 1 | Pop side: FIFO empty |
| rd_aempty | output | 1 | Pop side: at or below AE_LVL words |
| rd_half | output | 1 | Pop side: at least half full |
| rd_err | output | 1 | One-cycle pulse for a pop refused while empty |

## Verification
The hardest situation to reach is a push and a pop landing on nearly coincident edges of the two clocks while the FIFO sits one word from empty or one word from full. In that case each side must decide on its limit flag before it has seen the other side's pointer move. The bench runs both clocks at the same rate with a fixed 1 ns skew, so every push edge has a pop edge 1 ns behind it. It raises both requests in the same window, which makes the near-coincident case happen on purpose. Long pop bursts and push bursts are also run in parallel with a single request from the other side, timed to arrive a few cycles before the limit.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Occupancy bands seen from the pop side
    typedef enum logic [1:0] {
        RD_EMPTY = 2'd0,
        RD_LOW   = 2'd1,
        RD_MID   = 2'd2,
        RD_HIGH  = 2'd3
    } rd_lvl_e;

    // Occupancy bands seen from the push side
    typedef enum logic [1:0] {
        WR_LOW  = 2'd0,
        WR_HALF = 2'd1,
        WR_NEAR = 2'd2,
        WR_FULL = 2'd3
    } wr_lvl_e;

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dcf_pop_side.sv
module dcf_pop_side
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int AE_LVL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_n,
    input  logic [ADDR_W:0]   wgray_s,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_gray,
    output logic              empty,
    output logic              aempty,
    output logic              half,
    output logic              err
);

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    rd_lvl_e        state, state_nx;
    logic [PW-1:0]  rbin, rbin_nx, wbin_s, lvl_nx;

    always_comb begin
        rd_en   = !pop_n && (state != RD_EMPTY);
        rbin_nx = rbin + PW'(rd_en);
        wbin_s  = g2b(wgray_s);
        lvl_nx  = wbin_s - rbin_nx;
    end

    // next-state choice: band of the occupancy after this cycle
    always_comb begin
        if (lvl_nx == '0)                 state_nx = RD_EMPTY;
        else if (lvl_nx <= PW'(AE_LVL))   state_nx = RD_LOW;
        else if (lvl_nx >= PW'(HALF))     state_nx = RD_HIGH;
        else                              state_nx = RD_MID;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin    <= '0;
            rd_gray <= '0;
            err     <= 1'b0;
        end else begin
            rbin    <= rbin_nx;
            rd_gray <= rbin_nx ^ (rbin_nx >> 1);
            err     <= !pop_n && (state == RD_EMPTY);
        end
    end

    // flag decode
    always_comb begin
        unique case (state)
            RD_EMPTY: begin empty = 1'b1; aempty = 1'b1; half = 1'b0; end
            RD_LOW:   begin empty = 1'b0; aempty = 1'b1; half = 1'b0; end
            RD_MID:   begin empty = 1'b0; aempty = 1'b0; half = 1'b0; end
            RD_HIGH:  begin empty = 1'b0; aempty = 1'b0; half = 1'b1; end
            default:  begin empty = 1'b1; aempty = 1'b1; half = 1'b0; end
        endcase
    end

    assign rd_addr = rbin[ADDR_W-1:0];

endmodule

// File: rtl/dcf_push_side.sv
module dcf_push_side
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int AF_LVL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_n,
    input  logic [ADDR_W:0]   rgray_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   wr_gray,
    output logic              full,
    output logic              afull,
    output logic              half,
    output logic              err
);

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;
    localparam int NEAR  = DEPTH - AF_LVL;
    // top two Gray bits differ when the writer is one lap ahead
    localparam logic [PW-1:0] LAP_MASK = {2'b11, {(PW-2){1'b0}}};

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    wr_lvl_e        state, state_nx;
    logic [PW-1:0]  wbin, wbin_nx, wgray_nx, rbin_s, lvl_nx;
    logic           lap_nx;

    always_comb begin
        wr_en    = !push_n && (state != WR_FULL);
        wbin_nx  = wbin + PW'(wr_en);
        wgray_nx = wbin_nx ^ (wbin_nx >> 1);
        rbin_s   = g2b(rgray_s);
        lvl_nx   = wbin_nx - rbin_s;
        lap_nx   = (wgray_nx == (rgray_s ^ LAP_MASK));
    end

    // next-state choice: full from the Gray lap test, others from occupancy
    always_comb begin
        if (lap_nx)                      state_nx = WR_FULL;
        else if (lvl_nx >= PW'(NEAR))    state_nx = WR_NEAR;
        else if (lvl_nx >= PW'(HALF))    state_nx = WR_HALF;
        else                             state_nx = WR_LOW;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_LOW;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin    <= '0;
            wr_gray <= '0;
            err     <= 1'b0;
        end else begin
            wbin    <= wbin_nx;
            wr_gray <= wgray_nx;
            err     <= !push_n && (state == WR_FULL);
        end
    end

    // flag decode
    always_comb begin
        unique case (state)
            WR_LOW:  begin full = 1'b0; afull = 1'b0; half = 1'b0; end
            WR_HALF: begin full = 1'b0; afull = 1'b0; half = 1'b1; end
            WR_NEAR: begin full = 1'b0; afull = 1'b1; half = 1'b1; end
            WR_FULL: begin full = 1'b1; afull = 1'b1; half = 1'b1; end
            default: begin full = 1'b0; afull = 1'b0; half = 1'b0; end
        endcase
    end

    assign wr_addr = wbin[ADDR_W-1:0];

endmodule

// File: rtl/dcfifo_ctrl.sv
module dcfifo_ctrl #(
    parameter int ADDR_W    = 3,
    parameter int AE_LVL    = 1,
    parameter int AF_LVL    = 1,
    parameter int SYNC_STGS = 2
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              push_n,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_full,
    output logic              wr_afull,
    output logic              wr_half,
    output logic              wr_err,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              pop_n,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_empty,
    output logic              rd_aempty,
    output logic              rd_half,
    output logic              rd_err
);

    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wgray, wgray_s, rgray, rgray_s;

    dcf_push_side #(.ADDR_W(ADDR_W), .AF_LVL(AF_LVL)) u_push (
        .clk     (wclk),
        .rst_n   (wrst_n),
        .push_n  (push_n),
        .rgray_s (rgray_s),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_gray (wgray),
        .full    (wr_full),
        .afull   (wr_afull),
        .half    (wr_half),
        .err     (wr_err)
    );

    dcf_pop_side #(.ADDR_W(ADDR_W), .AE_LVL(AE_LVL)) u_pop (
        .clk     (rclk),
        .rst_n   (rrst_n),
        .pop_n   (pop_n),
        .wgray_s (wgray_s),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_gray (rgray),
        .empty   (rd_empty),
        .aempty  (rd_aempty),
        .half    (rd_half),
        .err     (rd_err)
    );

    // write pointer into the pop domain
    dcf_gray_sync #(.W(PW), .STAGES(SYNC_STGS)) u_w2r (
        .clk   (rclk),
        .rst_n (rrst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    // read pointer into the push domain
    dcf_gray_sync #(.W(PW), .STAGES(SYNC_STGS)) u_r2w (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

endmodule

// File: rtl/dcfifo_ctrl_chk.sv
module dcfifo_ctrl_chk #(
    parameter int ADDR_W = 3
) (
    input logic              wclk,
    input logic              wrst_n,
    input logic              push_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_full,
    input logic              rclk,
    input logic              rrst_n,
    input logic              pop_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_empty
);

    // R2
    wr_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_en |=> wr_addr == ADDR_W'($past(wr_addr) + 1'b1));

    // R3
    rd_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        rd_en |=> rd_addr == ADDR_W'($past(rd_addr) + 1'b1));

    // R4
    empty_after_pop_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        $rose(rd_empty) |-> $past(rd_en));

    // R5
    full_after_push_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        $rose(wr_full) |-> $past(wr_en));

    // R10
    push_drop_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_full && !push_n) |=> $stable(wr_addr));

    // R11
    pop_drop_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_empty && !pop_n) |=> $stable(rd_addr));

endmodule

bind dcfifo_ctrl dcfifo_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .wclk     (wclk),
    .wrst_n   (wrst_n),
    .push_n   (push_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_full  (wr_full),
    .rclk     (rclk),
    .rrst_n   (rrst_n),
    .pop_n    (pop_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_empty (rd_empty)
);

// File: tb/test_dcfifo_ctrl.sv
module test_dcfifo_ctrl;

    localparam int ADDR_W = 3;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int AE     = 1;
    localparam int AF     = 1;

    logic wclk = 1'b0, rclk = 1'b0;
    logic wrst_n = 1'b0, rrst_n = 1'b0;
    logic push_n = 1'b1, pop_n = 1'b1;
    logic wr_en, rd_en, wr_full, wr_afull, wr_half, wr_err;
    logic rd_empty, rd_aempty, rd_half, rd_err;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [7:0] wr_data = '0;
    logic [7:0] mem [DEPTH];

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [7:0] mdl [256];
    int hd = 0, tl = 0;
    logic [7:0] seq = 8'h10;

    // 125 MHz on both sides, pop edges trail push edges by 1 ns
    always #4 wclk = ~wclk;
    initial begin
        #1;
        forever #4 rclk = ~rclk;
    end

    dcfifo_ctrl #(.ADDR_W(ADDR_W), .AE_LVL(AE), .AF_LVL(AF)) i_dcfifo_ctrl (
        .wclk(wclk), .wrst_n(wrst_n), .push_n(push_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_full(wr_full), .wr_afull(wr_afull),
        .wr_half(wr_half), .wr_err(wr_err),
        .rclk(rclk), .rrst_n(rrst_n), .pop_n(pop_n), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_empty(rd_empty), .rd_aempty(rd_aempty),
        .rd_half(rd_half), .rd_err(rd_err)
    );

    always_ff @(posedge wclk) if (wr_en) mem[wr_addr] <= wr_data;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge rclk);
        #2;
    endtask

    // flags against the model occupancy (R4 R5 R6)
    task automatic chk_flags();
        int lvl;
        lvl = tl - hd;
        chk("R4 empty",  32'(rd_empty),  32'(lvl == 0));
        chk("R4 aempty", 32'(rd_aempty), 32'(lvl <= AE));
        chk("R6 rd_half", 32'(rd_half),  32'(lvl >= DEPTH / 2));
        chk("R5 full",   32'(wr_full),   32'(lvl == DEPTH));
        chk("R5 afull",  32'(wr_afull),  32'(lvl >= DEPTH - AF));
        chk("R6 wr_half", 32'(wr_half),  32'(lvl >= DEPTH / 2));
    endtask

    task automatic push_words(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge wclk); #2;
            if (!wr_full) begin
                chk("R2 wr_addr", 32'(wr_addr), 32'(tl % DEPTH));
                push_n = 1'b0;
                wr_data = seq;
                mdl[tl % 256] = seq;
                tl++;
                seq++;
            end else push_n = 1'b1;
        end
        @(posedge wclk); #2;
        push_n = 1'b1;
    endtask

    task automatic pop_words(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge rclk); #2;
            if (!rd_empty) begin
                chk("R3 rd_addr", 32'(rd_addr), 32'(hd % DEPTH));
                chk("R3 data", 32'(mem[rd_addr]), 32'(mdl[hd % 256]));
                pop_n = 1'b0;
                hd++;
            end else pop_n = 1'b1;
        end
        @(posedge rclk); #2;
        pop_n = 1'b1;
    endtask

    // {pushes, pops} per entry
    localparam logic [15:0] VEC [9] = '{
        16'h0100, 16'h0300, 16'h0300, 16'h0100, 16'h0002,
        16'h0006, 16'h0201, 16'h0001, 16'h0505
    };

    initial begin
        #1_600_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #21;
        wrst_n = 1'b1;
        rrst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1 empty",  32'(rd_empty),  32'd1);
        chk("R1 aempty", 32'(rd_aempty), 32'd1);
        chk("R1 rd_half", 32'(rd_half),  32'd0);
        chk("R1 full",   32'(wr_full),   32'd0);
        chk("R1 afull",  32'(wr_afull),  32'd0);
        chk("R1 wr_half", 32'(wr_half),  32'd0);
        chk("R1 errs",   32'({wr_err, rd_err}), 32'd0);
        chk("R1 addrs",  32'({wr_addr, rd_addr}), 32'd0);

        // vector table
        foreach (VEC[k]) begin
            push_words(int'(VEC[k][15:8]));
            settle();
            pop_words(int'(VEC[k][7:0]));
            settle();
            chk_flags();
        end

        // R7: one word, push and pop on near-coincident edges
        push_words(1);
        settle();
        @(posedge wclk); #2;
        chk("R7 data", 32'(mem[rd_addr]), 32'(mdl[hd % 256]));
        hd++;
        pop_n = 1'b0;
        push_n = 1'b0;
        wr_data = seq; mdl[tl % 256] = seq; tl++; seq++;
        @(posedge wclk); #2;
        push_n = 1'b1;
        pop_n = 1'b1;
        chk("R7 empty after pop", 32'(rd_empty), 32'd1);
        settle();
        chk_flags();
        pop_words(2);
        settle();
        chk_flags();

        // R8: DEPTH-1 words, push and pop on near-coincident edges
        push_words(DEPTH - 1);
        settle();
        @(posedge wclk); #2;
        chk("R8 data", 32'(mem[rd_addr]), 32'(mdl[hd % 256]));
        hd++;
        pop_n = 1'b0;
        push_n = 1'b0;
        wr_data = seq; mdl[tl % 256] = seq; tl++; seq++;
        @(posedge wclk); #2;
        push_n = 1'b1;
        pop_n = 1'b1;
        chk("R8 full after push", 32'(wr_full), 32'd1);
        settle();
        chk("R8 full released", 32'(wr_full), 32'd0);
        chk_flags();
        pop_words(DEPTH + 2);
        settle();
        chk_flags();

        // R9: pop burst to empty, late push
        push_words(6);
        settle();
        fork
            pop_words(14);
            begin repeat (4) @(posedge wclk); push_words(1); end
        join
        settle();
        chk("R9 drained", 32'(tl - hd), 32'd0);
        chk_flags();

        // R9 mirrored: push burst to full, late pop
        push_words(2);
        settle();
        fork
            push_words(14);
            begin repeat (4) @(posedge rclk); pop_words(1); end
        join
        settle();
        chk("R9 filled", 32'(tl - hd), 32'(DEPTH));
        chk_flags();

        // R10: push while full is dropped
        @(posedge wclk); #2;
        push_n = 1'b0;
        wr_data = 8'hEE;
        @(posedge wclk); #2;
        push_n = 1'b1;
        chk("R10 err pulse", 32'(wr_err), 32'd1);
        chk("R10 addr held", 32'(wr_addr), 32'(tl % DEPTH));
        @(posedge wclk); #2;
        chk("R10 err one cycle", 32'(wr_err), 32'd0);
        pop_words(DEPTH + 1);
        settle();
        chk_flags();

        // R11: pop while empty is dropped
        @(posedge rclk); #2;
        pop_n = 1'b0;
        @(posedge rclk); #2;
        pop_n = 1'b1;
        chk("R11 err pulse", 32'(rd_err), 32'd1);
        chk("R11 addr held", 32'(rd_addr), 32'(hd % DEPTH));
        @(posedge rclk); #2;
        chk("R11 err one cycle", 32'(rd_err), 32'd0);
        push_words(1);
        settle();
        pop_words(2);
        settle();
        chk_flags();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule